// File: doc/BRIEF.md
# Configurable External Interrupt Controller

This block gathers a set of external interrupt pins, each of which may change at any time relative to the system clock. It synchronises every pin and watches it for the event chosen in that pin's own sense field. The event can be a low level, a high level, a rising edge, a falling edge or either edge. A detected event sets a sticky bit in a detect-status register. Each pin has its own interrupt output, which is raised while both its detect bit and its enable bit are set.

Software works through a small word-addressed register port with a write strobe and a read strobe. Enables are never changed by read-modify-write. One write-only location sets enable bits. Another location clears enable bits when written and returns the current enable mask when read. A handler servicing pin n acknowledges it by writing a one to bit n of the detect-status register. If the pin is in a level mode and its level is still active, the bit sets again.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every enable bit, detect bit and configuration register is zero, and every interrupt output is low.
- R2: A pin change passes two synchroniser flops before detection. When pin n rises in high-level mode, irq_out[n] is still low at the second clock edge after the change and high at the third.
- R3: Sense value 0x01 detects a low level and 0x02 detects a high level. While the active level persists, the detect bit stays set even in the cycle it is written one to clear.
- R4: Sense value 0x04 detects a falling edge, 0x08 a rising edge and 0x0C either edge. Once cleared, the bit stays clear until a new qualifying edge arrives.
- R5: Any other sense value, 0x00 included, never sets that pin's detect bit.
- R6: The detect-status register is at byte offset 0x100, with bit n for pin n. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R7: Writing 1s to offset 0x08 sets enable bits, and writing 1s to offset 0x04 clears them. Reading 0x04 returns the enable mask, and reading 0x08 returns 0.
- R8: Offset 0x00 reads the detect status ANDed with the enable mask.
- R9: irq_out[n] is high exactly when detect bit n and enable bit n are both 1.
- R10: Pin n's configuration register is at offset 0x180 + 4*n. Bits [5:0] hold the sense field and bits above read as zero. A write changes only the addressed pin's field.
- R11: bus_rdata is loaded at the clock edge where bus_rd is high and holds its value otherwise. An unmapped or misaligned address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | NUM_PINS | External interrupt pins, asynchronous to clk |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, data appears after the next edge |
| bus_rdata | output | DATA_W | Registered read data |
| irq_out | output | NUM_PINS | Per-pin interrupt requests |

## Verification
A wrong detect bit or enable bit shows at irq_out and in the request-status word. It appears at the clock edge after the faulty update, or three edges after the pin change that should have caused it. A wrong sense field shows as a pin that never fires or one that fires on the wrong event, and it can be read back at the pin's configuration offset one cycle after the read strobe. The sweep drives every pin through every sense encoding plus two invalid ones. Because the other pins have sense 0 during each sweep step, a decode fault that touches a neighbouring pin appears as a stray bit in the full status word.

// File: rtl/eic_pkg.sv
// Package: shared sense encodings and register offsets of the
// external interrupt controller. Offsets are byte addresses.
package eic_pkg;
    localparam int SENSE_W = 6;

    typedef enum logic [SENSE_W-1:0] {
        SNS_OFF  = 6'h00,
        SNS_LOW  = 6'h01,
        SNS_HIGH = 6'h02,
        SNS_FALL = 6'h04,
        SNS_RISE = 6'h08,
        SNS_BOTH = 6'h0C
    } sense_e;

    localparam int OFS_REQ      = 'h000;
    localparam int OFS_EN_CLR   = 'h004;
    localparam int OFS_EN_SET   = 'h008;
    localparam int OFS_DET      = 'h100;
    localparam int OFS_CFG_BASE = 'h180;
endpackage

// File: rtl/eic_sync.sv
// Module: eic_sync
// Brings W asynchronous pins into the clock domain through two flops,
// then keeps one more flop holding the synchronised value one clock
// earlier so that edges can be found by comparison.
// Assumes: pins are stable for at least one clock per level.
module eic_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_async,
    output logic [W-1:0] lvl_now,
    output logic [W-1:0] lvl_prev
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] hist_q;

    // Purpose: three-stage shift of every pin (two sync, one history).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= pin_async;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign lvl_now  = sync_q;
    assign lvl_prev = hist_q;
endmodule

// File: rtl/eic_sense.sv
// Module: eic_sense
// Decides for one pin whether the event selected by its sense field is
// present in this cycle. Purely combinational.
// Assumes: lvl_now/lvl_prev come from the synchroniser; an encoding not
// in the package list yields no event.
module eic_sense
    import eic_pkg::*;
(
    input  logic [SENSE_W-1:0] sense,
    input  logic               lvl_now,
    input  logic               lvl_prev,
    output logic               hit
);
    // Purpose: map sense encoding and pin history onto a hit.
    always_comb begin
        case (sense)
            SNS_LOW:  hit = !lvl_now;
            SNS_HIGH: hit = lvl_now;
            SNS_FALL: hit = !lvl_now && lvl_prev;
            SNS_RISE: hit = lvl_now && !lvl_prev;
            SNS_BOTH: hit = lvl_now ^ lvl_prev;
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/eic_bus_decode.sv
// Module: eic_bus_decode
// Turns a byte address into one-hot selects for the fixed registers
// and a select plus index for the per-pin configuration bank.
// Assumes: ADDR_W >= 9 so the configuration bank is addressable.
module eic_bus_decode
    import eic_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_PINS = 32,
    parameter int IDX_W    = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              sel_req,
    output logic              sel_en_clr,
    output logic              sel_en_set,
    output logic              sel_det,
    output logic              sel_cfg,
    output logic [IDX_W-1:0]  cfg_idx
);
    localparam logic [ADDR_W-1:0] A_REQ   = ADDR_W'(OFS_REQ);
    localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'(OFS_EN_CLR);
    localparam logic [ADDR_W-1:0] A_ENSET = ADDR_W'(OFS_EN_SET);
    localparam logic [ADDR_W-1:0] A_DET   = ADDR_W'(OFS_DET);
    localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(OFS_CFG_BASE);
    localparam logic [ADDR_W-1:0] CFG_SPAN = ADDR_W'(NUM_PINS * 4);

    logic [ADDR_W-1:0] cfg_off;

    // Purpose: compare the address with every mapped location.
    always_comb begin
        cfg_off    = addr - A_CFG;
        sel_req    = (addr == A_REQ);
        sel_en_clr = (addr == A_ENCLR);
        sel_en_set = (addr == A_ENSET);
        sel_det    = (addr == A_DET);
        sel_cfg    = (addr >= A_CFG) && (cfg_off < CFG_SPAN) && (addr[1:0] == 2'b00);
        cfg_idx    = cfg_off[IDX_W+1:2];
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
// Module: ext_irq_ctrl (top)
// External interrupt controller: per-pin synchroniser and sense
// detection, sticky write-one-to-clear detect status, set/clear enable
// registers, per-pin configuration, one interrupt output per pin.
// Assumes: NUM_PINS <= DATA_W, single-cycle write/read strobes,
// synchronous active-low reset.
module ext_irq_ctrl
    import eic_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_wr,
    input  logic                bus_rd,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_PINS-1:0] irq_out
);
    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic [NUM_PINS-1:0] lvl_now, lvl_prev, hit_vec;
    logic [NUM_PINS-1:0] det_q, en_q;
    logic [NUM_PINS-1:0] det_clr, en_clr, en_set;
    logic [SENSE_W-1:0]  cfg_q [NUM_PINS];
    logic [NUM_PINS*SENSE_W-1:0] cfg_flat;
    logic sel_req, sel_en_clr, sel_en_set, sel_det, sel_cfg;
    logic [IDX_W-1:0] cfg_idx;
    logic [DATA_W-1:0] rd_mux;

    eic_sync #(.W(NUM_PINS)) sync_i (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_in),
        .lvl_now(lvl_now), .lvl_prev(lvl_prev)
    );

    eic_bus_decode #(.ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) dec_i (
        .addr(bus_addr), .sel_req(sel_req), .sel_en_clr(sel_en_clr),
        .sel_en_set(sel_en_set), .sel_det(sel_det), .sel_cfg(sel_cfg),
        .cfg_idx(cfg_idx)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        eic_sense sense_i (
            .sense(cfg_q[g]), .lvl_now(lvl_now[g]),
            .lvl_prev(lvl_prev[g]), .hit(hit_vec[g])
        );

        // Purpose: hold pin g's sense field, written only at its own offset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_q[g] <= '0;
            else if (bus_wr && sel_cfg && (cfg_idx == IDX_W'(g)))
                cfg_q[g] <= bus_wdata[SENSE_W-1:0];
        end

        assign cfg_flat[g*SENSE_W +: SENSE_W] = cfg_q[g];
    end

    // Purpose: derive the per-bit clear and set masks of this write.
    always_comb begin
        det_clr = (bus_wr && sel_det)    ? bus_wdata[NUM_PINS-1:0] : '0;
        en_clr  = (bus_wr && sel_en_clr) ? bus_wdata[NUM_PINS-1:0] : '0;
        en_set  = (bus_wr && sel_en_set) ? bus_wdata[NUM_PINS-1:0] : '0;
    end

    // Purpose: sticky detect status; a new hit outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            det_q <= '0;
        else
            det_q <= (det_q & ~det_clr) | hit_vec;
    end

    // Purpose: enable mask, changed only through the set and clear offsets.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else
            en_q <= (en_q & ~en_clr) | en_set;
    end

    // Purpose: select the read value for the addressed location.
    always_comb begin
        if (sel_req)
            rd_mux = DATA_W'(det_q & en_q);
        else if (sel_en_clr)
            rd_mux = DATA_W'(en_q);
        else if (sel_det)
            rd_mux = DATA_W'(det_q);
        else if (sel_cfg)
            rd_mux = DATA_W'(cfg_q[cfg_idx]);
        else
            rd_mux = '0;
    end

    // Purpose: register read data on the read strobe, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

    assign irq_out = det_q & en_q;
endmodule

// File: rtl/eic_checker.sv
// Module: eic_checker
// Concurrent checks on the controller, bound to every ext_irq_ctrl.
// Assumes: the same parameters as the bound instance.
module eic_checker
    import eic_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic [DATA_W-1:0]            bus_wdata,
    input logic                         bus_wr,
    input logic                         bus_rd,
    input logic [DATA_W-1:0]            bus_rdata,
    input logic [NUM_PINS-1:0]          irq_out,
    input logic [NUM_PINS-1:0]          det_q,
    input logic [NUM_PINS-1:0]          en_q,
    input logic [NUM_PINS*SENSE_W-1:0]  cfg_flat
);
    logic [NUM_PINS-1:0] clr_seen_q;

    // Purpose: remember the detect-clear mask of the last write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            clr_seen_q <= '0;
        else if (bus_wr && (bus_addr == ADDR_W'(OFS_DET)))
            clr_seen_q <= bus_wdata[NUM_PINS-1:0];
        else
            clr_seen_q <= '0;
    end

    function automatic logic sense_ok(input logic [SENSE_W-1:0] s);
        return (s == 6'h01) || (s == 6'h02) || (s == 6'h04) || (s == 6'h08) || (s == 6'h0C);
    endfunction

    AST_DET_FALLS_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(det_q) & ~det_q) & ~clr_seen_q) == '0)); // R6

    AST_EN_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr) |-> $stable(en_q)); // R7

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out & ~en_q) == '0)); // R9

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> $stable(bus_rdata)); // R11

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
        AST_INVALID_NO_DET: assert property (@(posedge clk) disable iff (!rst_n)
            (!sense_ok($past(cfg_flat[g*SENSE_W +: SENSE_W])) && !$past(det_q[g])) |-> !det_q[g]); // R5
    end
endmodule

bind ext_irq_ctrl eic_checker #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .det_q(det_q), .en_q(en_q), .cfg_flat(cfg_flat)
);

// File: tb/ext_irq_ctrl_tb_top.sv
// Bench: sweeps every pin of an 8-pin controller through all sense
// encodings plus invalid ones; expected values computed arithmetically.
module ext_irq_ctrl_tb_top;
    localparam int NP = 8;
    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_in = '0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic [NP-1:0] irq_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ext_irq_ctrl #(.NUM_PINS(NP), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // {low, high, rise, fall} responses of a sense value
    function automatic logic [3:0] resp(input logic [5:0] m);
        return {m == 6'h01, m == 6'h02, (m == 6'h08) || (m == 6'h0C), (m == 6'h04) || (m == 6'h0C)};
    endfunction

    function automatic string tag(input logic [5:0] m);
        if (m == 6'h01 || m == 6'h02) return "R3";
        if (m == 6'h04 || m == 6'h08 || m == 6'h0C) return "R4";
        return "R5";
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        logic [5:0] modes [8];
        modes = '{6'h00, 6'h01, 6'h02, 6'h04, 6'h08, 6'h0C, 6'h03, 6'h30};

        idle(4);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq_out", 32'(irq_out), 0);
        rd(12'h000, d); chk("R1 request", d, 0);
        rd(12'h004, d); chk("R1 enable", d, 0);
        rd(12'h100, d); chk("R1 detect", d, 0);
        rd(12'h19C, d); chk("R1 config7", d, 0);

        // R7: enable set / clear / read
        wr(12'h008, 32'hA5);
        rd(12'h004, d); chk("R7 set", d, 32'hA5);
        wr(12'h004, 32'h21);
        rd(12'h004, d); chk("R7 clear", d, 32'h84);
        wr(12'h008, 32'h0);
        rd(12'h004, d); chk("R7 zero set", d, 32'h84);
        rd(12'h008, d); chk("R7 set reads 0", d, 0);
        // R11: read data holds when no read strobe
        rd(12'h004, d);
        wr(12'h004, 32'hFF);
        chk("R11 hold", bus_rdata, 32'h84);
        rd(12'h0FC, d); chk("R11 unmapped", d, 0);
        rd(12'h181, d); chk("R11 misaligned", d, 0);

        // R10: configuration field width and independence
        wr(12'h18C, 32'hFFFF_FFFF);
        rd(12'h18C, d); chk("R10 cfg3 width", d, 32'h3F);
        rd(12'h188, d); chk("R10 cfg2 untouched", d, 0);
        rd(12'h190, d); chk("R10 cfg4 untouched", d, 0);
        wr(12'h18C, 32'h0);
        rd(12'h18C, d); chk("R10 cfg3 restored", d, 0);

        // R2: synchroniser latency on pin 0, high-level mode
        wr(12'h180, 32'h02);
        wr(12'h008, 32'h01);
        @(negedge clk); pin_in[0] = 1'b1;
        idle(2); chk("R2 not yet", 32'(irq_out), 0);
        idle(1); chk("R2 third edge", 32'(irq_out), 1);
        pin_in[0] = 1'b0;
        wr(12'h180, 32'h0);
        idle(4);
        wr(12'h100, 32'hFF);
        wr(12'h004, 32'hFF);
        rd(12'h100, d); chk("R6 cleanup", d, 0);

        // Sweep: every pin through every sense value
        for (int p = 0; p < NP; p++) begin
            for (int k = 0; k < 8; k++) begin
                logic [5:0] m;
                logic [3:0] r;
                logic [NP-1:0] bit_p, en_m, e;
                m = modes[k];
                r = resp(m);
                bit_p = NP'(1) << p;
                en_m = bit_p | (NP'(1) << ((p + 1) % NP));
                wr(12'h008, 32'(en_m));
                wr(AW'(12'h180 + 4 * p), 32'(m));
                idle(4);
                wr(12'h100, 32'hFF);
                // phase 0: pin low, status just cleared
                e = r[3] ? bit_p : '0;
                rd(12'h100, d); chk(tag(m), d, 32'(e));
                chk("R9 irq", 32'(irq_out), 32'(e & en_m));
                // phase 1: pin raised
                @(negedge clk); pin_in[p] = 1'b1;
                idle(4);
                e = (r[3] | r[2] | r[1]) ? bit_p : '0;
                rd(12'h100, d); chk(tag(m), d, 32'(e));
                rd(12'h000, d); chk("R8 request", d, 32'(e & en_m));
                wr(12'h100, 32'(~bit_p));
                rd(12'h100, d); chk("R6 zero bit kept", d, 32'(e));
                wr(12'h100, 32'(bit_p));
                e = r[2] ? bit_p : '0;
                rd(12'h100, d); chk(tag(m), d, 32'(e));
                chk("R9 irq", 32'(irq_out), 32'(e & en_m));
                // phase 2: pin lowered
                @(negedge clk); pin_in[p] = 1'b0;
                idle(4);
                e = (r[3] | r[2] | r[0]) ? bit_p : '0;
                rd(12'h100, d); chk(tag(m), d, 32'(e));
                wr(12'h100, 32'(bit_p));
                e = r[3] ? bit_p : '0;
                rd(12'h100, d); chk(tag(m), d, 32'(e));
                rd(AW'(12'h180 + 4 * p), d); chk("R10 cfg readback", d, 32'(m));
                // cleanup
                wr(AW'(12'h180 + 4 * p), 32'h0);
                idle(2);
                wr(12'h100, 32'hFF);
                wr(12'h004, 32'hFF);
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule